// File: doc/BRIEF.md
# Binary-Search Conversion Controller

This block runs the digital side of a search-type analog-to-digital conversion. It drives a trial code to an external resistor-ladder DAC. In the same cycle it reads back a three-way comparison between the ladder voltage and the analog input. It keeps a low and a high bound on the answer and halves the remaining range after each comparison. The search stops at once when the comparator reports equality. It also stops when the bounds cross or when a fixed step budget is used up.

Each conversion starts from mid-scale in normal mode. In tracking mode it starts from the previous result instead, which converges in one step when the input has not moved. The block uses a one-cycle start pulse and a one-cycle done pulse. The result and a no-exact-match flag stay valid between conversions.

Top module: `binSearchAdc`

## Requirements
- R1: The comparator inputs mean: `cmpMatch`=1 ladder equals input (takes priority); otherwise `cmpAbove`=1 ladder above input, `cmpAbove`=0 ladder below. On "above" the high bound becomes trial−1. On "below" the low bound becomes trial+1. The next trial is floor((low+high)/2). For a 3-bit code and an input equal to code 7, the trial codes are 3, 5, 6, 7.
- R2: When `cmpMatch` is 1 during a search cycle, the current trial code becomes `result`, `noExact` is 0 and the conversion ends.
- R3: A conversion performs at most MAX_STEPS (default CODE_W+1) comparisons, one per busy cycle.
- R4: In normal mode (`trackMode`=0) the bounds start at 0 and 2^CODE_W−1, and the first trial is floor((2^CODE_W−1)/2), which is 3 for CODE_W=3.
- R5: In tracking mode (`trackMode`=1) the first trial is the previous `result`, and the bounds start at full scale.
- R6: If a comparison would make the bounds cross, the search ends, the last trial is reported as `result` and `noExact` is 1.
- R7: A start pulse while idle makes `busy` rise on the next cycle. A start while busy has no effect on the running conversion.
- R8: `done` is high for exactly one cycle, in the cycle after the final comparison. `result` and `noExact` change only at that point and are held otherwise.
- R9: The asynchronous active-low reset `rstN` clears `busy`, `done`, `result`, `noExact`, the bounds and the trial code to 0 at once, so a tracking conversion after reset starts from code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| trackMode | input | 1 | 1: seed with previous result; 0: seed mid-scale |
| cmpAbove | input | 1 | Ladder voltage above analog input |
| cmpMatch | input | 1 | Ladder voltage equal to analog input |
| trialCode | output | CODE_W | Code driven to the ladder DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | CODE_W | Last conversion result |
| noExact | output | 1 | Last conversion ended without equality |

## Verification
The hardest situation to reach is a search that ends without equality, because a comparator driven by a code-aligned input always finds a match. The bench models the analog input in half-step units. An odd value falls between two codes, so the bounds must cross, and the expected last trial is worked out by hand. The tracking-mode worst case is also hard to reach. The bench gets there by first converting a full-scale input, then converting zero with tracking on, which forces the full step budget.

// File: rtl/adcSearchPkg.sv
package adcSearchPkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } searchState_t;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic load;     // seed bounds and first trial
    logic advance;  // narrow bounds, next trial
    logic finish;   // capture result and flag
  } searchStrobe_t;

endpackage

// File: rtl/adcSearchDatapath.sv
module adcSearchDatapath
  import adcSearchPkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  searchStrobe_t       strobe,
  input  logic                trackMode,
  input  logic                cmpAbove,
  input  logic                cmpMatch,
  output logic                boundsCross,
  output logic [CODE_W-1:0]   trialCode,
  output logic [CODE_W-1:0]   result,
  output logic                noExact
);

  localparam logic [CODE_W-1:0] FULL_CODE = '1;
  localparam logic [CODE_W-1:0] MID_CODE  = FULL_CODE >> 1;

  logic [CODE_W-1:0] loQ, hiQ, guessQ, resultQ;
  logic              noExactQ;
  logic [CODE_W-1:0] nextLo, nextHi, nextGuess, seedGuess;
  logic [CODE_W:0]   midSum;

  // the trial always lies within [lo, hi], so a crossing shows up
  // as a move past a bound that the trial already sits on
  always_comb begin
    boundsCross = 1'b0;
    if (!cmpMatch) begin
      if (cmpAbove) boundsCross = (guessQ == loQ);
      else          boundsCross = (guessQ == hiQ);
    end
  end

  always_comb begin
    nextLo = loQ;
    nextHi = hiQ;
    if (!cmpMatch) begin
      if (cmpAbove) nextHi = guessQ - 1'b1;
      else          nextLo = guessQ + 1'b1;
    end
    midSum    = {1'b0, nextLo} + {1'b0, nextHi};
    nextGuess = midSum[CODE_W:1];
    seedGuess = trackMode ? resultQ : MID_CODE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ      <= '0;
      hiQ      <= '0;
      guessQ   <= '0;
      resultQ  <= '0;
      noExactQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        loQ    <= '0;
        hiQ    <= FULL_CODE;
        guessQ <= seedGuess;
      end else if (strobe.advance) begin
        loQ    <= nextLo;
        hiQ    <= nextHi;
        guessQ <= nextGuess;
      end
      if (strobe.finish) begin
        resultQ  <= guessQ;
        noExactQ <= !cmpMatch;
      end
    end
  end

  assign trialCode = guessQ;
  assign result    = resultQ;
  assign noExact   = noExactQ;

endmodule

// File: rtl/adcSearchCtrl.sv
module adcSearchCtrl
  import adcSearchPkg::*;
#(
  parameter int MAX_STEPS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cmpMatch,
  input  logic          boundsCross,
  output searchStrobe_t strobe,
  output logic          busy,
  output logic          done
);

  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

  searchState_t      stateQ;
  logic [STEP_W-1:0] stepCnt;
  logic              doneQ;
  logic              endNow;

  always_comb begin
    endNow         = cmpMatch || boundsCross || (stepCnt == LAST_STEP);
    strobe.load    = (stateQ == ST_IDLE) && start;
    strobe.advance = (stateQ == ST_SEARCH) && !endNow;
    strobe.finish  = (stateQ == ST_SEARCH) && endNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (strobe.load) begin
        stateQ  <= ST_SEARCH;
        stepCnt <= '0;
      end else if (strobe.advance) begin
        stepCnt <= stepCnt + 1'b1;
      end else if (strobe.finish) begin
        stateQ <= ST_IDLE;
      end
    end
  end

  assign busy = (stateQ == ST_SEARCH);
  assign done = doneQ;

endmodule

// File: rtl/binSearchAdc.sv
module binSearchAdc
  import adcSearchPkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int MAX_STEPS = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              trackMode,
  input  logic              cmpAbove,
  input  logic              cmpMatch,
  output logic [CODE_W-1:0] trialCode,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] result,
  output logic              noExact
);

  searchStrobe_t strobe;
  logic          boundsCross;

  adcSearchCtrl #(.MAX_STEPS(MAX_STEPS)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cmpMatch    (cmpMatch),
    .boundsCross (boundsCross),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  adcSearchDatapath #(.CODE_W(CODE_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .trackMode   (trackMode),
    .cmpAbove    (cmpAbove),
    .cmpMatch    (cmpMatch),
    .boundsCross (boundsCross),
    .trialCode   (trialCode),
    .result      (result),
    .noExact     (noExact)
  );

endmodule

// File: rtl/binSearchAdcChk.sv
module binSearchAdcChk #(
  parameter int CODE_W    = 3,
  parameter int MAX_STEPS = CODE_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              trackMode,
  input logic              cmpAbove,
  input logic              cmpMatch,
  input logic [CODE_W-1:0] trialCode,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] result,
  input logic              noExact
);

  localparam logic [CODE_W-1:0] FULL_CODE = '1;
  localparam logic [CODE_W-1:0] MID_CODE  = FULL_CODE >> 1;
  localparam int CNT_W = $clog2(MAX_STEPS + 2);

  logic [CNT_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= (busyRun == CNT_W'(MAX_STEPS + 1)) ? busyRun : busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= CNT_W'(MAX_STEPS)); // R3

  AST_EXACT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmpMatch |=> done && !noExact && (result == $past(trialCode))); // R2

  AST_NORMAL_SEED: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start && !trackMode |=> busy && (trialCode == MID_CODE)); // R4

  AST_TRACK_SEED: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start && trackMode |=> busy && (trialCode == $past(result))); // R5

  AST_CROSS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    busy && !cmpMatch && !cmpAbove && (trialCode == FULL_CODE) |=> done && noExact); // R6

  AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start |=> busy); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) || !$stable(noExact) |-> done); // R8

endmodule

bind binSearchAdc binSearchAdcChk #(.CODE_W(CODE_W), .MAX_STEPS(MAX_STEPS)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .trackMode (trackMode),
  .cmpAbove  (cmpAbove),
  .cmpMatch  (cmpMatch),
  .trialCode (trialCode),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .noExact   (noExact)
);

// File: tb/test_binSearchAdc.sv
module test_binSearchAdc;

  localparam int CODE_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              trackMode = 1'b0;
  logic              cmpAbove, cmpMatch;
  logic [CODE_W-1:0] trialCode, result;
  logic              busy, done, noExact;
  logic [CODE_W:0]   anaHalf = '0;   // analog input in half-code units

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  // ladder and comparator model: ladder level for code c is 2c half-units
  assign cmpAbove = ({trialCode, 1'b0} > anaHalf);
  assign cmpMatch = ({trialCode, 1'b0} == anaHalf);

  binSearchAdc #(.CODE_W(CODE_W)) i_binSearchAdc (
    .clk(clk), .rstN(rstN), .start(start), .trackMode(trackMode),
    .cmpAbove(cmpAbove), .cmpMatch(cmpMatch), .trialCode(trialCode),
    .busy(busy), .done(done), .result(result), .noExact(noExact)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int steps, trace[8];
  int doneAfter;

  // one conversion; pokeAt>0 pulses start again during that busy cycle
  task automatic convert(input bit mode, input int ana, input int pokeAt);
    @(negedge clk);
    anaHalf = (CODE_W+1)'(ana);
    trackMode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    steps = 0;
    for (int i = 0; i < 8; i++) trace[i] = -1;
    for (int g = 0; g < 40 && !done; g++) begin
      if (busy) begin
        if (steps < 8) trace[steps] = int'(trialCode);
        steps++;
      end
      start = (pokeAt != 0 && steps == pokeAt);
      @(negedge clk);
    end
    start = 1'b0;
    checkEq("R8 done seen", int'(done), 1);
    @(negedge clk);
    doneAfter = int'(done);
  endtask

  task automatic tReset();
    checkEq("R9 reset busy", int'(busy), 0);
    checkEq("R9 reset done", int'(done), 0);
    checkEq("R9 reset result", int'(result), 0);
    checkEq("R9 reset noExact", int'(noExact), 0);
    checkEq("R9 reset trial", int'(trialCode), 0);
  endtask

  task automatic tExactSweep();
    for (int t = 0; t < 8; t++) begin
      convert(1'b0, 2*t, 0);
      checkEq("R2 exact result", int'(result), t);
      checkEq("R2 exact flag", int'(noExact), 0);
      checkEq("R4 first trial mid", trace[0], 3);
      checkEq("R3 steps within limit", int'(steps <= 4), 1);
      checkEq("R8 done one cycle", doneAfter, 0);
    end
    convert(1'b0, 6, 0);
    checkEq("R2 early exit steps", steps, 1);
  endtask

  task automatic tTrace();
    convert(1'b0, 14, 0);
    checkEq("R1 trace0", trace[0], 3);
    checkEq("R1 trace1", trace[1], 5);
    checkEq("R1 trace2", trace[2], 6);
    checkEq("R1 trace3", trace[3], 7);
    checkEq("R3 steps full", steps, 4);
    convert(1'b0, 0, 0);
    checkEq("R1 down trace1", trace[1], 1);
    checkEq("R1 down trace2", trace[2], 0);
    checkEq("R1 down steps", steps, 3);
  endtask

  task automatic tNoMatch();
    convert(1'b0, 5, 0);
    checkEq("R6 cross result a5", int'(result), 2);
    checkEq("R6 cross flag a5", int'(noExact), 1);
    checkEq("R6 cross steps a5", steps, 3);
    convert(1'b0, 11, 0);
    checkEq("R6 cross result a11", int'(result), 6);
    checkEq("R6 cross flag a11", int'(noExact), 1);
    convert(1'b0, 15, 0);
    checkEq("R6 cross result a15", int'(result), 7);
    checkEq("R3 cross steps a15", steps, 4);
    convert(1'b0, 4, 0);
    checkEq("R2 flag cleared", int'(noExact), 0);
  endtask

  task automatic tTrack();
    convert(1'b0, 10, 0);
    convert(1'b1, 10, 0);
    checkEq("R5 seed prev", trace[0], 5);
    checkEq("R5 one step", steps, 1);
    checkEq("R5 result", int'(result), 5);
    convert(1'b0, 14, 0);
    convert(1'b1, 0, 0);
    checkEq("R5 far seed", trace[0], 7);
    checkEq("R5 far trace1", trace[1], 3);
    checkEq("R5 far trace3", trace[3], 0);
    checkEq("R3 far steps", steps, 4);
    checkEq("R5 far result", int'(result), 0);
  endtask

  task automatic tStartIgnored();
    convert(1'b0, 14, 2);
    checkEq("R7 busy start steps", steps, 4);
    checkEq("R7 busy start result", int'(result), 7);
    checkEq("R7 no restart", int'(busy), 0);
    checkEq("R8 single done", doneAfter, 0);
  endtask

  task automatic tHold();
    convert(1'b0, 12, 0);
    anaHalf = 4'd2;
    repeat (5) @(negedge clk);
    checkEq("R8 result held", int'(result), 6);
    checkEq("R8 done low idle", int'(done), 0);
    checkEq("R8 flag held", int'(noExact), 0);
  endtask

  task automatic tAsyncReset();
    convert(1'b0, 14, 0);
    @(negedge clk);
    anaHalf = 4'd14;
    trackMode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    #5 rstN = 1'b0;
    #1;
    checkEq("R9 async busy", int'(busy), 0);
    checkEq("R9 async result", int'(result), 0);
    checkEq("R9 async trial", int'(trialCode), 0);
    @(negedge clk);
    rstN = 1'b1;
    convert(1'b1, 0, 0);
    checkEq("R9 track after reset seed", trace[0], 0);
    checkEq("R9 track after reset steps", steps, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExactSweep();
    tTrace();
    tNoMatch();
    tTrack();
    tStartIgnored();
    tHold();
    tAsyncReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule